// File: doc/BRIEF.md
# Reciprocal-Multiply Constant Divider

This block divides an unsigned 32-bit dividend by a divisor that stays fixed for the operation. It does not iterate. The caller supplies the divisor already converted into three values:

- the upper 32 bits of a scaled reciprocal;
- a flag saying the full reciprocal needs 33 bits;
- a final right-shift count.

The block multiplies the dividend by the stored reciprocal word. When the flag is set, it adds half the dividend into the low half of the 64-bit product. It then shifts the upper word right to form the quotient.

A stored reciprocal of zero marks a divisor that is a power of two. In that case the multiply is skipped and the dividend itself is shifted.

Operands enter through a valid/ready handshake and results leave through another, one quotient per accepted dividend and in the same order. There are three register stages: multiply, correction add and shift. A stall at the output freezes the whole pipeline.

Top module: `recip_divider`

## Requirements
- R1: After reset, `out_valid_o` is 0 and `in_ready_o` is 1.
- R2: For a nonzero reciprocal word R, the quotient equals the upper 32 bits of (dividend × R + C) shifted right by `shift_i`. C is floor(dividend/2) when `wide_i` is 1 and 0 otherwise. With parameters derived from a divisor d, this equals floor(dividend/d) for every 32-bit dividend and every d from 1 to 2^32−1.
- R3: A carry out of the low 32 bits of the correction add reaches the upper word. For example, dividend 0xFFFFFFFF, R=1, `wide_i`=1, shift 0 gives quotient 1.
- R4: With `wide_i`=0 no correction is added. For example, dividend 0xFFFFFFFF, R=1, shift 0 gives quotient 0.
- R5: When R=0, the quotient is the dividend shifted right by `shift_i`, and `wide_i` has no effect.
- R6: A divisor of 1, encoded as R=0 and shift 0, returns the dividend unchanged.
- R7: With `out_ready_i` held high, a dividend accepted at a clock edge produces its quotient with `out_valid_o` high after the third edge, counting the accepting edge as the first.
- R8: While `out_valid_o` is 1 and `out_ready_i` is 0, `quotient_o` and `out_valid_o` hold their values and `in_ready_o` is 0.
- R9: Results leave in acceptance order. With `out_ready_i` high, one dividend can be accepted and one quotient delivered every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand triple and dividend are valid |
| in_ready_o | output | 1 | Block accepts an operand this cycle |
| dividend_i | input | 32 | Unsigned dividend |
| recip_i | input | 32 | Upper word of the scaled reciprocal; 0 selects the power-of-two path |
| wide_i | input | 1 | Reciprocal needs 33 bits; enables the half-dividend correction |
| shift_i | input | 5 | Right shift applied to the upper product word |
| out_valid_o | output | 1 | Quotient is valid |
| out_ready_i | input | 1 | Consumer takes the quotient |
| quotient_o | output | 32 | Quotient |

## Verification
The assertions assume that reset is applied before the first operand and that every handshake input carries a known value at each edge. The carry check also relies on the correction term being at most half the dividend; the datapath enforces this for every reciprocal word, so no limit is placed on the operand triple.

The stimulus keeps the handshake inputs defined at all times. It changes inputs only between edges and holds an offered operand steady until it is accepted. Operand triples come from a bench routine that derives them from the divisor, except for a few directed raw triples aimed at the carry, correction and power-of-two paths.

// File: rtl/recip_div_pkg.sv
package recip_div_pkg;
  localparam int unsigned DEF_DW = 32;

  function automatic int unsigned shift_bits(input int unsigned dw);
    return $clog2(dw);
  endfunction
endpackage

// File: rtl/recip_mul_stage.sv
module recip_mul_stage
  import recip_div_pkg::*;
#(
  parameter int unsigned DW = DEF_DW,
  localparam int unsigned SW = shift_bits(DW),
  localparam int unsigned PW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          valid_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [DW-1:0] recip_i,
  input  logic          wide_i,
  input  logic [SW-1:0] shift_i,
  output logic          valid_o,
  output logic [PW-1:0] prod_o,
  output logic [DW-1:0] corr_o,
  output logic [SW-1:0] shift_o
);
  logic          bypass;
  logic [DW-1:0] corr_mask;
  logic [PW-1:0] prod_d;

  assign bypass    = (recip_i == '0);
  assign corr_mask = {DW{wide_i & ~bypass}};
  assign prod_d    = bypass ? {dividend_i, {DW{1'b0}}}
                            : {{DW{1'b0}}, dividend_i} * {{DW{1'b0}}, recip_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      prod_o  <= '0;
      corr_o  <= '0;
      shift_o <= '0;
    end else if (en_i) begin
      valid_o <= valid_i;
      if (valid_i) begin
        prod_o  <= prod_d;
        corr_o  <= corr_mask & (dividend_i >> 1);
        shift_o <= shift_i;
      end
    end
  end

  // R5
  bypass_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && valid_i && recip_i == '0 |=> prod_o[PW-1:DW] == $past(dividend_i) && corr_o == '0);
endmodule

// File: rtl/recip_fix_stage.sv
module recip_fix_stage
  import recip_div_pkg::*;
#(
  parameter int unsigned DW = DEF_DW,
  parameter bit          SPLIT_CARRY = 1'b1,
  localparam int unsigned SW = shift_bits(DW),
  localparam int unsigned PW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          valid_i,
  input  logic [PW-1:0] prod_i,
  input  logic [DW-1:0] corr_i,
  input  logic [SW-1:0] shift_i,
  output logic          valid_o,
  output logic [DW-1:0] hi_o,
  output logic [SW-1:0] shift_o
);
  logic [DW-1:0] hi_d;

  generate
    if (SPLIT_CARRY) begin : g_split
      logic [DW:0] lo_sum;
      assign lo_sum = {1'b0, prod_i[DW-1:0]} + {1'b0, corr_i};
      assign hi_d   = prod_i[PW-1:DW] + {{(DW-1){1'b0}}, lo_sum[DW]};
    end else begin : g_full
      logic [PW-1:0] sum;
      assign sum  = prod_i + {{DW{1'b0}}, corr_i};
      assign hi_d = sum[PW-1:DW];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      hi_o    <= '0;
      shift_o <= '0;
    end else if (en_i) begin
      valid_o <= valid_i;
      if (valid_i) begin
        hi_o    <= hi_d;
        shift_o <= shift_i;
      end
    end
  end

  // R3
  carry_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && valid_i |=> hi_o == $past(prod_i[PW-1:DW]) || hi_o == $past(prod_i[PW-1:DW]) + 1'b1);

  // R4
  no_corr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && valid_i && corr_i == '0 |=> hi_o == $past(prod_i[PW-1:DW]));
endmodule

// File: rtl/recip_shift_stage.sv
module recip_shift_stage
  import recip_div_pkg::*;
#(
  parameter int unsigned DW = DEF_DW,
  localparam int unsigned SW = shift_bits(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          valid_i,
  input  logic [DW-1:0] hi_i,
  input  logic [SW-1:0] shift_i,
  output logic          valid_o,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] stg [SW+1];

  assign stg[0] = hi_i;

  generate
    for (genvar i = 0; i < SW; i++) begin : g_bs
      localparam int unsigned AMT = 1 << i;
      assign stg[i+1] = shift_i[i] ? (stg[i] >> AMT) : stg[i];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      q_o     <= '0;
    end else if (en_i) begin
      valid_o <= valid_i;
      if (valid_i) q_o <= stg[SW];
    end
  end

  // R2
  shift_shrinks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && valid_i |=> q_o <= $past(hi_i));
endmodule

// File: rtl/recip_divider.sv
module recip_divider
  import recip_div_pkg::*;
#(
  parameter int unsigned DW = DEF_DW,
  localparam int unsigned SW = shift_bits(DW),
  localparam int unsigned PW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [DW-1:0] dividend_i,
  input  logic [DW-1:0] recip_i,
  input  logic          wide_i,
  input  logic [SW-1:0] shift_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [DW-1:0] quotient_o
);
  logic          adv;
  logic          s1_valid, s2_valid;
  logic [PW-1:0] s1_prod;
  logic [DW-1:0] s1_corr, s2_hi;
  logic [SW-1:0] s1_shift, s2_shift;

  // whole pipe stalls only when the output is held
  assign adv        = ~out_valid_o | out_ready_i;
  assign in_ready_o = adv;

  recip_mul_stage #(.DW(DW)) u_mul (
    .clk_i, .rst_ni, .en_i(adv), .valid_i(in_valid_i),
    .dividend_i, .recip_i, .wide_i, .shift_i,
    .valid_o(s1_valid), .prod_o(s1_prod), .corr_o(s1_corr), .shift_o(s1_shift)
  );

  recip_fix_stage #(.DW(DW)) u_fix (
    .clk_i, .rst_ni, .en_i(adv), .valid_i(s1_valid),
    .prod_i(s1_prod), .corr_i(s1_corr), .shift_i(s1_shift),
    .valid_o(s2_valid), .hi_o(s2_hi), .shift_o(s2_shift)
  );

  recip_shift_stage #(.DW(DW)) u_shf (
    .clk_i, .rst_ni, .en_i(adv), .valid_i(s2_valid),
    .hi_i(s2_hi), .shift_i(s2_shift),
    .valid_o(out_valid_o), .q_o(quotient_o)
  );

  // R8
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(quotient_o));

  // R7
  accept_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> s1_valid);

  // R9
  stage_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2_valid && out_ready_i |=> out_valid_o);
endmodule

// File: tb/recip_divider_tb.sv
`timescale 1ns/1ps
module recip_divider_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [31:0] dividend = '0, recip = '0;
  logic        wide = 1'b0;
  logic [4:0]  shift = '0;
  logic        out_valid, out_ready = 1'b0;
  logic [31:0] quotient;

  int total = 0, fails = 0, cyc = 0;
  bit lat_mode = 0, done = 0;
  bit held = 0;
  logic [31:0] held_q;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  int          acc_q[$];

  always #2 clk = ~clk;

  recip_divider u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .dividend_i(dividend), .recip_i(recip), .wide_i(wide), .shift_i(shift),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .quotient_o(quotient)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic void mk_params(input logic [31:0] d, output logic [31:0] r,
                                    output logic w, output logic [4:0] s);
    int l = 0;
    logic [65:0] num, m;
    while ((64'd1 << l) < {32'd0, d}) l++;
    if ((d & (d - 1)) == 0) begin
      r = '0; w = 1'b0; s = 5'(l);
    end else begin
      num = 66'd1 << (32 + l);
      m   = (num + {34'd0, d} - 66'd1) / {34'd0, d};
      r = m[32:1]; w = m[0]; s = 5'(l - 1);
    end
  endfunction

  function automatic logic [31:0] raw_q(input logic [31:0] n, r, input logic w, input logic [4:0] s);
    logic [63:0] p;
    if (r == 0) p = {n, 32'h0};
    else p = {32'h0, n} * {32'h0, r} + (w ? {33'h0, n[31:1]} : 64'h0);
    return p[63:32] >> s;
  endfunction

  // one clock: drive at negedge, evaluate handshakes just after
  task automatic tick(input logic v, input logic [31:0] n, r, input logic w, input logic [4:0] s,
                      input logic rdy, input logic [31:0] expv, input string tag, output bit acc);
    @(negedge clk);
    cyc++;
    in_valid = v; dividend = n; recip = r; wide = w; shift = s; out_ready = rdy;
    #1;
    if (held) chk(out_valid && quotient == held_q, "R8 hold", quotient, held_q);
    if (out_valid && !rdy) chk(!in_ready, "R8 ready low", {31'd0, in_ready}, 32'd0);
    if (out_valid && rdy) begin
      if (exp_q.size() == 0) chk(0, "R9 spurious output", quotient, 32'hx);
      else begin
        logic [31:0] e = exp_q.pop_front();
        string t = tag_q.pop_front();
        int a = acc_q.pop_front();
        chk(quotient == e, t, quotient, e);
        if (lat_mode) chk(cyc - a == 3, "R7 latency", 32'(cyc - a), 32'd3);
      end
    end
    acc = v && in_ready;
    if (acc) begin
      exp_q.push_back(expv); tag_q.push_back(tag); acc_q.push_back(cyc);
    end
    held = out_valid && !rdy;
    held_q = quotient;
  endtask

  task automatic send(input logic [31:0] n, r, input logic w, input logic [4:0] s,
                      input logic [31:0] expv, input string tag, input bit rnd_rdy);
    bit acc = 0;
    while (!acc) tick(1'b1, n, r, w, s, rnd_rdy ? ($urandom_range(0, 3) != 0) : 1'b1, expv, tag, acc);
  endtask

  task automatic send_div(input logic [31:0] n, d, input string tag, input bit rnd_rdy);
    logic [31:0] r; logic w; logic [4:0] s;
    mk_params(d, r, w, s);
    send(n, r, w, s, n / d, tag, rnd_rdy);
  endtask

  task automatic drain();
    bit acc;
    int k = 0;
    while (exp_q.size() != 0 && k < 1000) begin
      tick(1'b0, '0, '0, 1'b0, '0, 1'b1, '0, "", acc);
      k++;
    end
    tick(1'b0, '0, '0, 1'b0, '0, 1'b1, '0, "", acc);
  endtask

  function automatic logic [31:0] rnd_div();
    logic [31:0] d;
    case ($urandom_range(0, 3))
      0: d = $urandom_range(1, 1000);
      1: d = 32'd1 << $urandom_range(0, 31);
      default: d = $urandom;
    endcase
    return (d == 0) ? 32'd1 : d;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    bit acc;
    logic [31:0] dl[8];
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    chk(!out_valid, "R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
    chk(in_ready, "R1 in_ready after reset", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;

    // directed, latency tracked
    lat_mode = 1;
    send(32'hDEADBEEF, 32'h0, 1'b0, 5'd0, 32'hDEADBEEF, "R6 divide by one", 0);
    drain();
    send(32'hF0F0_1234, 32'h0, 1'b1, 5'd4, 32'h0F0F_0123, "R5 bypass ignores wide", 0);
    drain();
    send(32'hFFFFFFFF, 32'h1, 1'b1, 5'd0, 32'd1, "R3 carry into high word", 0);
    drain();
    send(32'hFFFFFFFF, 32'h1, 1'b0, 5'd0, 32'd0, "R4 no correction", 0);
    drain();
    send(32'h1234_5678, 32'h9ABC_DEF1, 1'b0, 5'd3,
         raw_q(32'h1234_5678, 32'h9ABC_DEF1, 1'b0, 5'd3), "R2 raw triple", 0);
    drain();

    // R9 back-to-back burst
    dl = '{3, 7, 10, 641, 32'hFFFFFFFF, 32'h80000001, 6, 32'h10000};
    foreach (dl[i]) send_div(32'hFFFFFFFF - 32'(i), dl[i], "R9 burst", 0);
    drain();
    lat_mode = 0;

    // R2 boundary dividends
    foreach (dl[i]) begin
      send_div(32'd0, dl[i], "R2 zero dividend", 1);
      send_div(dl[i] - 1, dl[i], "R2 d-1", 1);
      send_div(dl[i], dl[i], "R2 n=d", 1);
      send_div(32'hFFFFFFFF, dl[i], "R2 max dividend", 1);
    end

    // R2/R8 random with stalls and gaps
    for (int i = 0; i < 1500; i++) begin
      if ($urandom_range(0, 4) == 0)
        tick(1'b0, '0, '0, 1'b0, '0, ($urandom_range(0, 3) != 0), '0, "", acc);
      send_div($urandom, rnd_div(), "R2 random", 1);
    end
    drain();
    chk(exp_q.size() == 0, "R9 all results returned", 32'(exp_q.size()), 32'd0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule